// File: doc/BRIEF.md
# Flash Feature Access Sequencer

This block is a host-side engine that reads and writes the per-device feature settings of a flash memory on an 8-bit asynchronous bus. One request carries a direction (get or set), an 8-bit feature address and four parameter bytes. The engine drives the chip enables, the command and address latch strobes, the write and read strobes and the data bus. It measures every bus timing in clock cycles.

A set request is sent as a command cycle, one address cycle, a mandated address-to-data pause and then four data cycles. A get request is sent as a command cycle and one address cycle. The engine then waits for the device to report ready and strobes four bytes back, which it presents as one 32-bit word. Feature address 01h also pulls a second chip enable low for the whole transaction.

The controller is a single enumerated state machine: `S_IDLE`, `S_CE_SETUP`, `S_CMD_LO`, `S_CMD_HI`, `S_ADR_LO`, `S_ADR_HI`, `S_DAT_LO`, `S_DAT_HI`, `S_WAIT_RDY`, `S_RD_LO`, `S_RD_HI` and `S_FINISH`. Each timed state lasts a set number of cycles, loaded into a down-counter when the state is entered.

The transitions are:
- `S_IDLE` goes to `S_CE_SETUP` on start.
- `S_CE_SETUP` goes to `S_CMD_LO`, then `S_CMD_HI`, then `S_ADR_LO`, then `S_ADR_HI`.
- From `S_ADR_HI`, a set request goes to `S_DAT_LO` and a get request goes to `S_WAIT_RDY`.
- `S_DAT_LO` and `S_DAT_HI` alternate four times, then go to `S_FINISH`.
- `S_WAIT_RDY` goes to `S_RD_LO` once its counter has expired and ready is high.
- `S_RD_LO` and `S_RD_HI` alternate four times, then go to `S_FINISH`.
- `S_FINISH` returns to `S_IDLE`.

Top module: `flash_feat_seq`

## Requirements
- R1: A set request issues one command cycle with cle_o high and dq_o = EFh, followed by one address cycle with ale_o high and dq_o = the feature address. A get request does the same with dq_o = EEh. Each cycle is latched by the rising edge of we_n_o. cle_o and ale_o are never high together.
- R2: After the address cycle, a set request issues exactly four data cycles with cle_o and ale_o low. They carry params_i[7:0], params_i[15:8], params_i[23:16] and params_i[31:24], in that order, as captured at start. dq_oe_o is high whenever we_n_o is low.
- R3: In a set request, we_n_o stays high for exactly T_ADL cycles between the rising edge that ends the address cycle and the falling edge of the first data cycle.
- R4: In a get request, after the address cycle the engine waits at least T_WB cycles. It then waits until rdy_i (1 = ready) is high before the first read strobe. re_n_o never falls while rdy_i is low during that wait, and exactly four read strobes follow.
- R5: ce2_n_o is low throughout a transaction whose feature address is 01h. For every other address it stays high. ce2_n_o is never low while ce_n_o is high.
- R6: ce_n_o falls exactly T_CS cycles before the first falling edge of we_n_o. During those cycles we_n_o is high and cle_o and ale_o are low.
- R7: Each write strobe is low for T_WP cycles. Each read strobe is low for T_RP cycles. we_n_o and re_n_o are never low together.
- R8: At the end of a get request, rd_data_o holds the four bytes read, the first in bits [7:0] and the fourth in bits [31:24]. rd_valid_o pulses for one cycle together with done_o. It never pulses for a set request.
- R9: A start pulse while busy_o is high is ignored. The bus sequence of the running transaction is unchanged and no second transaction follows.
- R10: busy_o is high from the cycle after an accepted start until done_o. done_o is a single-cycle pulse after which busy_o is low.
- R11: During and after reset, ce_n_o, ce2_n_o, we_n_o and re_n_o are high, and cle_o, ale_o, dq_oe_o, busy_o, done_o and rd_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request pulse |
| op_get_i | input | 1 | 1 = get, 0 = set |
| faddr_i | input | 8 | Feature address |
| params_i | input | 32 | Parameter bytes P1 in [7:0] to P4 in [31:24] |
| rdy_i | input | 1 | Device ready (1) / busy (0) |
| dq_i | input | 8 | Data bus from device |
| ce_n_o | output | 1 | Primary chip enable, active low |
| ce2_n_o | output | 1 | Second chip enable, active low |
| cle_o | output | 1 | Command latch strobe |
| ale_o | output | 1 | Address latch strobe |
| we_n_o | output | 1 | Write strobe, active low |
| re_n_o | output | 1 | Read strobe, active low |
| dq_o | output | 8 | Data bus to device |
| dq_oe_o | output | 1 | Data bus drive enable |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| rd_valid_o | output | 1 | Read data valid pulse |
| rd_data_o | output | 32 | Four bytes returned by a get |

## Verification
The strobe outputs are decoded from the state register, so every edge appears in the cycle after the clock edge that enters its state. The bench samples on falling clock edges and stamps each edge with a cycle count. The spacings T_CS, T_WP, T_RP and T_ADL are checked as exact differences between those stamps, not as minimums. rd_data_o and rd_valid_o are due in the S_FINISH cycle, which is the same cycle as done_o, and they are read there. The idle check is made three cycles after done_o so that an ignored start would have had time to show up as a new transaction.

// File: rtl/flash_feat_pkg.sv
package flash_feat_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CE_SETUP,
        S_CMD_LO,
        S_CMD_HI,
        S_ADR_LO,
        S_ADR_HI,
        S_DAT_LO,
        S_DAT_HI,
        S_WAIT_RDY,
        S_RD_LO,
        S_RD_HI,
        S_FINISH
    } fsm_t;

    localparam logic [7:0] OPC_SET      = 8'hEF;
    localparam logic [7:0] OPC_GET      = 8'hEE;
    localparam logic [7:0] DUAL_CE_ADDR = 8'h01;

endpackage

// File: rtl/fs_timer.sv
module fs_timer #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fs_rd_capture.sv
module fs_rd_capture #(
    parameter int NB = 4,
    parameter int DW = 8
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            cap_i,
    input  logic [DW-1:0]   din_i,
    output logic [NB*DW-1:0] dout_o
);
    logic [NB*DW-1:0] sh_q;

    // Each new byte enters at the top, so the first byte read ends up in the low bits.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q <= '0;
        end else if (cap_i) begin
            sh_q <= {din_i, sh_q[NB*DW-1:DW]};
        end
    end

    assign dout_o = sh_q;
endmodule

// File: rtl/flash_feat_seq.sv
module flash_feat_seq
    import flash_feat_pkg::*;
#(
    parameter int T_CS    = 2,
    parameter int T_WP    = 2,
    parameter int T_WH    = 1,
    parameter int T_ADL   = 4,
    parameter int T_WB    = 2,
    parameter int T_RP    = 2,
    parameter int T_REH   = 1,
    parameter int TIMER_W = 8
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        start_i,
    input  logic        op_get_i,
    input  logic [7:0]  faddr_i,
    input  logic [31:0] params_i,
    input  logic        rdy_i,
    input  logic [7:0]  dq_i,
    output logic        ce_n_o,
    output logic        ce2_n_o,
    output logic        cle_o,
    output logic        ale_o,
    output logic        we_n_o,
    output logic        re_n_o,
    output logic [7:0]  dq_o,
    output logic        dq_oe_o,
    output logic        busy_o,
    output logic        done_o,
    output logic        rd_valid_o,
    output logic [31:0] rd_data_o
);
    localparam int NBYTES = 4;
    localparam int IDX_W  = $clog2(NBYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);
    localparam logic [TIMER_W-1:0] LEN_CS  = TIMER_W'(T_CS - 1);
    localparam logic [TIMER_W-1:0] LEN_WP  = TIMER_W'(T_WP - 1);
    localparam logic [TIMER_W-1:0] LEN_WH  = TIMER_W'(T_WH - 1);
    localparam logic [TIMER_W-1:0] LEN_ADL = TIMER_W'(T_ADL - 1);
    localparam logic [TIMER_W-1:0] LEN_WB  = TIMER_W'(T_WB - 1);
    localparam logic [TIMER_W-1:0] LEN_RP  = TIMER_W'(T_RP - 1);
    localparam logic [TIMER_W-1:0] LEN_REH = TIMER_W'(T_REH - 1);

    fsm_t state, state_n;

    logic                 op_q;
    logic [7:0]           faddr_q;
    logic [31:0]          params_q;
    logic [IDX_W-1:0]     idx_q;
    logic                 idx_clr, idx_inc;
    logic                 t_load, t_zero;
    logic [TIMER_W-1:0]   t_val;
    logic                 cap;

    fs_timer #(.W(TIMER_W)) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (t_load),
        .load_val_i (t_val),
        .zero_o     (t_zero)
    );

    fs_rd_capture #(.NB(NBYTES), .DW(8)) u_cap (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cap_i  (cap),
        .din_i  (dq_i),
        .dout_o (rd_data_o)
    );

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state <= S_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // Request capture and byte index
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            op_q     <= 1'b0;
            faddr_q  <= '0;
            params_q <= '0;
            idx_q    <= '0;
        end else begin
            if (state == S_IDLE && start_i) begin
                op_q     <= op_get_i;
                faddr_q  <= faddr_i;
                params_q <= params_i;
            end
            if (idx_clr) begin
                idx_q <= '0;
            end else if (idx_inc) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Next state and timer control
    always_comb begin
        state_n = state;
        t_load  = 1'b0;
        t_val   = '0;
        cap     = 1'b0;
        idx_clr = 1'b0;
        idx_inc = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start_i) begin
                    state_n = S_CE_SETUP;
                    t_load  = 1'b1;
                    t_val   = LEN_CS;
                    idx_clr = 1'b1;
                end
            end
            S_CE_SETUP: begin
                if (t_zero) begin
                    state_n = S_CMD_LO;
                    t_load  = 1'b1;
                    t_val   = LEN_WP;
                end
            end
            S_CMD_LO: begin
                if (t_zero) begin
                    state_n = S_CMD_HI;
                    t_load  = 1'b1;
                    t_val   = LEN_WH;
                end
            end
            S_CMD_HI: begin
                if (t_zero) begin
                    state_n = S_ADR_LO;
                    t_load  = 1'b1;
                    t_val   = LEN_WP;
                end
            end
            S_ADR_LO: begin
                if (t_zero) begin
                    state_n = S_ADR_HI;
                    t_load  = 1'b1;
                    t_val   = op_q ? LEN_WH : LEN_ADL;
                end
            end
            S_ADR_HI: begin
                if (t_zero) begin
                    t_load = 1'b1;
                    if (op_q) begin
                        state_n = S_WAIT_RDY;
                        t_val   = LEN_WB;
                    end else begin
                        state_n = S_DAT_LO;
                        t_val   = LEN_WP;
                    end
                end
            end
            S_DAT_LO: begin
                if (t_zero) begin
                    state_n = S_DAT_HI;
                    t_load  = 1'b1;
                    t_val   = LEN_WH;
                end
            end
            S_DAT_HI: begin
                if (t_zero) begin
                    if (idx_q == LAST_IDX) begin
                        state_n = S_FINISH;
                    end else begin
                        state_n = S_DAT_LO;
                        t_load  = 1'b1;
                        t_val   = LEN_WP;
                        idx_inc = 1'b1;
                    end
                end
            end
            S_WAIT_RDY: begin
                if (t_zero && rdy_i) begin
                    state_n = S_RD_LO;
                    t_load  = 1'b1;
                    t_val   = LEN_RP;
                end
            end
            S_RD_LO: begin
                if (t_zero) begin
                    cap     = 1'b1;
                    state_n = S_RD_HI;
                    t_load  = 1'b1;
                    t_val   = LEN_REH;
                end
            end
            S_RD_HI: begin
                if (t_zero) begin
                    if (idx_q == LAST_IDX) begin
                        state_n = S_FINISH;
                    end else begin
                        state_n = S_RD_LO;
                        t_load  = 1'b1;
                        t_val   = LEN_RP;
                        idx_inc = 1'b1;
                    end
                end
            end
            S_FINISH: begin
                state_n = S_IDLE;
            end
            default: begin
                state_n = S_IDLE;
            end
        endcase
    end

    // Bus outputs decoded from the state register
    always_comb begin
        ce_n_o     = 1'b0;
        cle_o      = 1'b0;
        ale_o      = 1'b0;
        we_n_o     = 1'b1;
        re_n_o     = 1'b1;
        dq_o       = '0;
        dq_oe_o    = 1'b0;
        done_o     = 1'b0;
        rd_valid_o = 1'b0;
        unique case (state)
            S_IDLE: begin
                ce_n_o = 1'b1;
            end
            S_CE_SETUP, S_WAIT_RDY: begin
            end
            S_CMD_LO, S_CMD_HI: begin
                cle_o   = 1'b1;
                we_n_o  = (state != S_CMD_LO);
                dq_o    = op_q ? OPC_GET : OPC_SET;
                dq_oe_o = 1'b1;
            end
            S_ADR_LO, S_ADR_HI: begin
                ale_o   = 1'b1;
                we_n_o  = (state != S_ADR_LO);
                dq_o    = faddr_q;
                dq_oe_o = 1'b1;
            end
            S_DAT_LO, S_DAT_HI: begin
                we_n_o  = (state != S_DAT_LO);
                dq_o    = params_q[{idx_q, 3'b000} +: 8];
                dq_oe_o = 1'b1;
            end
            S_RD_LO: begin
                re_n_o = 1'b0;
            end
            S_RD_HI: begin
            end
            S_FINISH: begin
                ce_n_o     = 1'b1;
                done_o     = 1'b1;
                rd_valid_o = op_q;
            end
            default: begin
                ce_n_o = 1'b1;
            end
        endcase
    end

    assign ce2_n_o = ce_n_o | (faddr_q != DUAL_CE_ADDR);
    assign busy_o  = (state != S_IDLE);

endmodule

// File: rtl/fs_checks.sv
module fs_checks (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       ce_n_o,
    input logic       ce2_n_o,
    input logic       cle_o,
    input logic       ale_o,
    input logic       we_n_o,
    input logic       re_n_o,
    input logic       dq_oe_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       rd_valid_o,
    input logic [7:0] faddr_q
);
    p_cle_ale_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(cle_o && ale_o));

    p_drive_on_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_n_o |-> dq_oe_o);

    p_ce2_follows_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ce2_n_o |-> !ce_n_o);

    p_ce_setup_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ce_n_o) |-> (we_n_o && !cle_o && !ale_o));

    p_strobe_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(!we_n_o && !re_n_o));

    p_valid_with_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_o |-> done_o);

    p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !done_o) |=> $stable(faddr_q));

    p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !busy_o);

    p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (ce_n_o && we_n_o && re_n_o));
endmodule

bind flash_feat_seq fs_checks u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_n_o     (ce_n_o),
    .ce2_n_o    (ce2_n_o),
    .cle_o      (cle_o),
    .ale_o      (ale_o),
    .we_n_o     (we_n_o),
    .re_n_o     (re_n_o),
    .dq_oe_o    (dq_oe_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .rd_valid_o (rd_valid_o),
    .faddr_q    (faddr_q)
);

// File: tb/sim_flash_feat_seq.sv
`timescale 1ns/1ps
module sim_flash_feat_seq;
    localparam int T_CS  = 2;
    localparam int T_WP  = 2;
    localparam int T_WH  = 1;
    localparam int T_ADL = 4;
    localparam int T_WB  = 2;
    localparam int T_RP  = 2;
    localparam int T_REH = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic op_get = 1'b0;
    logic [7:0] faddr = '0;
    logic [31:0] params = '0;
    logic rdy;
    logic [7:0] dq_in;
    logic ce_n, ce2_n, cle, ale, we_n, re_n, dq_oe, busy, done, rd_valid;
    logic [7:0] dq_out;
    logic [31:0] rd_data;

    always #5 clk = ~clk;

    flash_feat_seq #(
        .T_CS(T_CS), .T_WP(T_WP), .T_WH(T_WH), .T_ADL(T_ADL),
        .T_WB(T_WB), .T_RP(T_RP), .T_REH(T_REH), .TIMER_W(8)
    ) u0 (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_get_i(op_get),
        .faddr_i(faddr), .params_i(params), .rdy_i(rdy), .dq_i(dq_in),
        .ce_n_o(ce_n), .ce2_n_o(ce2_n), .cle_o(cle), .ale_o(ale),
        .we_n_o(we_n), .re_n_o(re_n), .dq_o(dq_out), .dq_oe_o(dq_oe),
        .busy_o(busy), .done_o(done), .rd_valid_o(rd_valid), .rd_data_o(rd_data)
    );

    int errors = 0;
    int checks = 0;

    // Monitor state, refreshed at each accepted start
    int cyc = 0;
    int nwe, nre, re_bad, ndone, nvalid;
    int t_cefall, t_wefall1, t_cmd_fall, t_cmd_rise, t_addr_rise, t_dfall1, t_re_fall1, t_re_rise1;
    logic [9:0] wlog [0:7];
    logic ce2_lo_seen, ce2_hi_seen, cur_get;
    logic [31:0] rdcap;
    logic [7:0] cur_fa;
    logic prev_we = 1'b1, prev_re = 1'b1, prev_ce = 1'b1;
    int bcnt = 0;

    assign rdy   = (bcnt == 0);
    assign dq_in = cur_fa ^ (8'h11 * 8'(nre + 1));

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (bcnt > 0) bcnt <= bcnt - 1;
        if (start && !busy) begin
            nwe = 0; nre = 0; re_bad = 0; ndone = 0; nvalid = 0;
            t_cefall = -1; t_wefall1 = -1; t_cmd_fall = -1; t_cmd_rise = -1;
            t_addr_rise = -1; t_dfall1 = -1; t_re_fall1 = -1; t_re_rise1 = -1;
            ce2_lo_seen = 1'b0; ce2_hi_seen = 1'b0; rdcap = '0;
            cur_fa = faddr; cur_get = op_get;
        end else begin
            if (prev_ce && !ce_n) t_cefall = cyc;
            if (!ce_n) begin
                if (!ce2_n) ce2_lo_seen = 1'b1; else ce2_hi_seen = 1'b1;
            end
            if (prev_we && !we_n) begin
                if (t_wefall1 < 0) t_wefall1 = cyc;
                if (cle && t_cmd_fall < 0) t_cmd_fall = cyc;
                if (!cle && !ale && t_dfall1 < 0) t_dfall1 = cyc;
            end
            if (!prev_we && we_n) begin
                if (nwe < 8) wlog[nwe] = {cle, ale, dq_out};
                nwe = nwe + 1;
                if (cle && t_cmd_rise < 0) t_cmd_rise = cyc;
                if (ale) begin
                    t_addr_rise = cyc;
                    if (cur_get) bcnt <= 6;
                end
            end
            if (prev_re && !re_n) begin
                if (!rdy) re_bad = re_bad + 1;
                if (t_re_fall1 < 0) t_re_fall1 = cyc;
            end
            if (!prev_re && re_n) begin
                nre = nre + 1;
                if (t_re_rise1 < 0) t_re_rise1 = cyc;
            end
            if (done) ndone = ndone + 1;
            if (rd_valid) begin
                nvalid = nvalid + 1;
                rdcap = rd_data;
            end
        end
        prev_we = we_n;
        prev_re = re_n;
        prev_ce = ce_n;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic g, input logic [7:0] fa, input logic [31:0] p);
        @(posedge clk); #1;
        start = 1'b1; op_get = g; faddr = fa; params = p;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    function automatic logic [7:0] pbyte(input logic [7:0] fa, input int k);
        return 8'(fa * 3 + k * 37 + 1);
    endfunction

    task automatic run(input logic g, input logic [7:0] fa);
        logic [31:0] p;
        logic [31:0] exp_rd;
        int w;
        for (int k = 0; k < 4; k++) begin
            p[k*8 +: 8] = pbyte(fa, k);
            exp_rd[k*8 +: 8] = fa ^ (8'h11 * 8'(k + 1));
        end
        pulse_start(g, fa, p);
        @(negedge clk);
        chk(busy == 1'b1, "R10 busy after start", 32'(busy), 1);
        repeat (4) @(negedge clk);
        // Ignored start while busy: flipped direction, other address
        @(posedge clk); #1;
        start = 1'b1; op_get = ~g; faddr = 8'h55; params = 32'hDEADBEEF;
        @(posedge clk); #1;
        start = 1'b0;
        w = 0;
        while (ndone == 0 && w < 3000) begin
            @(negedge clk);
            w++;
        end
        chk(w < 3000, "R10 watchdog", 32'(w), 0);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && ndone == 1, "R9/R10 idle after done", {busy, 31'(ndone)}, 1);
        chk(wlog[0] == {2'b10, (g ? 8'hEE : 8'hEF)}, "R1 command cycle", 32'(wlog[0]), {2'b10, (g ? 8'hEE : 8'hEF)});
        chk(wlog[1] == {2'b01, fa}, "R1 R9 address cycle", 32'(wlog[1]), {2'b01, fa});
        chk(t_wefall1 - t_cefall == T_CS, "R6 ce setup", 32'(t_wefall1 - t_cefall), T_CS);
        chk(t_cmd_rise - t_cmd_fall == T_WP, "R7 write strobe width", 32'(t_cmd_rise - t_cmd_fall), T_WP);
        chk(ce2_lo_seen == (fa == 8'h01) && ce2_hi_seen == (fa != 8'h01), "R5 second enable",
            {ce2_lo_seen, ce2_hi_seen}, {(fa == 8'h01), (fa != 8'h01)});
        if (!g) begin
            chk(nwe == 6, "R2 write cycle count", 32'(nwe), 6);
            for (int k = 0; k < 4; k++)
                chk(wlog[k+2] == {2'b00, p[k*8 +: 8]}, "R2 parameter byte", 32'(wlog[k+2]), {2'b00, p[k*8 +: 8]});
            chk(t_dfall1 - t_addr_rise == T_ADL, "R3 address-to-data gap", 32'(t_dfall1 - t_addr_rise), T_ADL);
            chk(nvalid == 0 && nre == 0, "R8 no read on set", 32'(nvalid + nre), 0);
        end else begin
            chk(nwe == 2, "R4 write cycle count on get", 32'(nwe), 2);
            chk(nre == 4 && re_bad == 0, "R4 read strobes after ready", {16'(nre), 16'(re_bad)}, {16'd4, 16'd0});
            chk(t_re_rise1 - t_re_fall1 == T_RP, "R7 read strobe width", 32'(t_re_rise1 - t_re_fall1), T_RP);
            chk(nvalid == 1 && rdcap == exp_rd, "R8 read data", rdcap, exp_rd);
        end
    endtask

    initial begin
        logic [7:0] fas [0:5];
        fas[0] = 8'h00; fas[1] = 8'h01; fas[2] = 8'h02;
        fas[3] = 8'h80; fas[4] = 8'hFF; fas[5] = 8'h01;
        cur_fa = '0; nre = 0;
        repeat (3) @(negedge clk);
        chk({ce_n, ce2_n, we_n, re_n} == 4'hF && {cle, ale, dq_oe, busy, done, rd_valid} == 6'b0,
            "R11 reset state", {ce_n, ce2_n, we_n, re_n, cle, ale, dq_oe, busy, done, rd_valid}, 10'h3C0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0 && ce_n == 1'b1, "R11 idle after reset", {busy, ce_n}, 2'b01);
        for (int g = 0; g < 2; g++)
            for (int i = 0; i < 6; i++)
                run(g[0], fas[i]);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1500000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule